// File: doc/BRIEF.md
# HDLC Transmit Framer

This block turns a stream of host bytes into a bit-oriented HDLC/SDLC frame on one serial line. When the first byte arrives on an idle line, the block sends the opening flag by itself. It then shifts out the data least significant bit first, with a zero inserted after every run of five ones. After the data it appends the complemented CRC-16 and a closing flag. The host can also end a frame early with an abort.

All line activity advances on a one-cycle bit-rate enable, `bit_en`. Bytes enter over a valid/ready port. `s_ready` is high only on a `bit_en` cycle: when the line is idle, or when the last bit of the current byte is being sent. A byte transfers on any cycle where `s_valid` and `s_ready` are both high. The host must hold `s_valid` and its data until that happens. Marking a byte with `s_last` ends the message after that byte. If no byte is offered at a byte boundary, the block treats it as an underrun and closes the frame cleanly. A request-to-send output follows the host request, but it is held through the closing flag. The line can be NRZ or NRZI coded.

Top module: `hdlc_tx_framer`

## Requirements
- R1: After reset `txd` is 1, `rts_out` is 0 and `undr_eom` is 0. `s_ready` is 0 on every cycle where `bit_en` is 0.
- R2: The first byte taken while idle starts a frame. On that same `bit_en` cycle the first bit of the opening flag 0x7E goes out, with no host command needed.
- R3: Data bytes go out least significant bit first. After any five consecutive 1 bits in the data or CRC fields a 0 is inserted, including a run that ends on the last CRC bit. No 0 is inserted inside a flag or an abort.
- R4: The CRC is CRC-16 with polynomial x^16+x^12+x^5+1, processed in reflected form (0x8408). It is preset to 0xFFFF at each frame start, runs over all data bits, and is sent complemented, least significant bit first.
- R5: A follow-on byte is taken on the `bit_en` cycle that sends the last bit of the current byte. A byte marked `s_last`, or no byte offered at that point (underrun), leads straight to the CRC and then the closing flag 0x7E.
- R6: `undr_eom` goes to 1 when the CRC field starts, whether because of end of message or underrun. It clears on the `bit_en` cycle that starts the next frame.
- R7: A one-cycle `abort_req` is latched. On the next `bit_en` cycle during the opening flag, data or CRC, the frame is replaced by eight 1 bits, with no CRC and no flag, and the line then returns to idle. A request made while idle or during the closing flag has no effect.
- R8: `rts_out` is 1 whenever `rts_req` is 1. If `rts_req` falls, `rts_out` stays 1 until the first bit boundary after the last bit of the closing flag (the next `bit_en` cycle on an idle line).
- R9: With `nrzi_en` set, a 0 bit toggles the line and a 1 bit leaves it unchanged. The line starts each frame from high. In both codings the line is forced to 1 from the first bit boundary after the closing flag.
- R10: `txd` changes only on clock edges that follow a `bit_en` cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | Bit-rate enable, one cycle per line bit |
| nrzi_en | input | 1 | 1 selects NRZI coding, 0 selects NRZ |
| s_valid | input | 1 | Host byte valid |
| s_ready | output | 1 | Framer takes the byte this cycle |
| s_data | input | 8 | Host byte |
| s_last | input | 1 | Byte is the last of the message |
| abort_req | input | 1 | Pulse requesting a frame abort |
| rts_req | input | 1 | Host request-to-send |
| txd | output | 1 | Serial line output |
| rts_out | output | 1 | Request-to-send to the line |
| undr_eom | output | 1 | Underrun / end-of-message status |

## Verification
The bench compares the whole decoded line stream against a bit-exact frame built from the requirements. It uses bytes chosen to produce long runs of ones: 0xFF pairs, 0xF8 followed by 0x1F, and a data byte equal to the flag. A framer that misses a stuffing point, or stuffs inside a flag, shifts every later bit. A wrong CRC preset or bit order corrupts the last 16 bits before the closing flag. The bench also times the release of request-to-send against the last flag bit: one boundary too early cuts off the flag, and one too late holds the line. It checks that NRZI output returns high after the frame, and that an abort yields an unbroken run of ones instead of a closing flag. The status latch is checked for clearing on the very first tick of the next frame.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_DATA, ST_CRC, ST_CLOSE, ST_ABORT
  } tx_state_t;

  localparam int          FLAG_LEN = 8;
  localparam logic [7:0]  FLAG_PAT = 8'h7E;
endpackage

// File: rtl/hdlc_tx_crc.sv
module hdlc_tx_crc #(
  parameter int                 CRC_W = 16,
  parameter logic [CRC_W-1:0]   POLY  = 16'h8408,
  parameter logic [CRC_W-1:0]   INIT  = '1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic preset,
  input  logic upd_en,
  input  logic upd_bit,
  input  logic shift_en,
  output logic out_bit
);
  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        crc_q <= INIT;
    else if (preset)   crc_q <= INIT;
    else if (upd_en)   crc_q <= (crc_q >> 1) ^ ((crc_q[0] ^ upd_bit) ? POLY : '0);
    else if (shift_en) crc_q <= {1'b1, crc_q[CRC_W-1:1]};
  end

  assign out_bit = ~crc_q[0];

  // R4: preset at frame start never overlaps accumulation or output
  p_preset_alone_r4: assert property (@(posedge clk) disable iff (!rst_n)
    preset |-> !(upd_en || shift_en));
endmodule

// File: rtl/hdlc_tx_line.sv
module hdlc_tx_line (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic nrzi_en,
  input  logic idle,
  input  logic raw_bit,
  output logic txd
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b1;
    else if (bit_en) begin
      if (idle)         level_q <= 1'b1;
      else if (nrzi_en) level_q <= raw_bit ? level_q : ~level_q;
      else              level_q <= raw_bit;
    end
  end

  assign txd = level_q;

  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bit_en && idle) |-> txd);

  p_tick_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> $stable(txd));
endmodule

// File: rtl/hdlc_tx_rts.sv
module hdlc_tx_rts (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic line_idle,
  input  logic rts_req,
  output logic rts_out
);
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    hold_q <= 1'b0;
    else if (rts_req)              hold_q <= 1'b1;
    else if (bit_en && line_idle)  hold_q <= 1'b0;
  end

  assign rts_out = rts_req | hold_q;

  // R8: request-to-send never falls while a frame is on the line
  p_rts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_idle && $past(rts_out)) |-> rts_out);
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
  import hdlc_tx_pkg::*;
#(
  parameter int               DATA_W    = 8,
  parameter int               CRC_W     = 16,
  parameter logic [CRC_W-1:0] CRC_POLY  = 16'h8408,
  parameter int               STUFF_RUN = 5,
  parameter int               ABORT_LEN = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic              nrzi_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_last,
  input  logic              abort_req,
  input  logic              rts_req,
  output logic              txd,
  output logic              rts_out,
  output logic              undr_eom
);
  localparam int MAX_A   = (CRC_W > ABORT_LEN) ? CRC_W : ABORT_LEN;
  localparam int MAX_LEN = (MAX_A > DATA_W) ? MAX_A : DATA_W;
  localparam int IDX_W   = $clog2(MAX_LEN);
  localparam int ONES_W  = $clog2(STUFF_RUN + 1);
  localparam logic [IDX_W-1:0]  DATA_LAST  = IDX_W'(DATA_W - 1);
  localparam logic [IDX_W-1:0]  CRC_LAST   = IDX_W'(CRC_W - 1);
  localparam logic [IDX_W-1:0]  FLAG_LAST  = IDX_W'(FLAG_LEN - 1);
  localparam logic [IDX_W-1:0]  ABORT_LAST = IDX_W'(ABORT_LEN - 1);
  localparam logic [ONES_W-1:0] RUN_MAX    = ONES_W'(STUFF_RUN);

  tx_state_t          state;
  logic [IDX_W-1:0]   idx;
  logic [ONES_W-1:0]  ones;
  logic [DATA_W-1:0]  sh;
  logic               last_q, abort_pend;
  logic               crc_bit, cur_bit, raw_bit;
  logic               stuff_now, do_abort, byte_end, line_idle;

  assign stuff_now = (ones == RUN_MAX) &&
                     (state == ST_DATA || state == ST_CRC || state == ST_CLOSE);
  assign do_abort  = abort_pend &&
                     (state == ST_OPEN || state == ST_DATA || state == ST_CRC);
  assign byte_end  = (state == ST_DATA) && (idx == DATA_LAST) && !stuff_now && !do_abort;
  assign s_ready   = bit_en && ((state == ST_IDLE) || (byte_end && !last_q));
  assign line_idle = (state == ST_IDLE) && !s_valid;

  always_comb begin
    unique case (state)
      ST_OPEN, ST_CLOSE: cur_bit = FLAG_PAT[idx[2:0]];
      ST_DATA:           cur_bit = sh[0];
      ST_CRC:            cur_bit = crc_bit;
      ST_ABORT:          cur_bit = 1'b1;
      default:           cur_bit = FLAG_PAT[0];
    endcase
    raw_bit = do_abort ? 1'b1 : (stuff_now ? 1'b0 : cur_bit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; idx <= '0; ones <= '0; sh <= '0;
      last_q <= 1'b0; abort_pend <= 1'b0; undr_eom <= 1'b0;
    end else begin
      if (bit_en) begin
        if (do_abort) begin
          state <= ST_ABORT; idx <= IDX_W'(1); ones <= '0; abort_pend <= 1'b0;
        end else begin
          unique case (state)
            ST_IDLE: begin
              abort_pend <= 1'b0;
              if (s_valid) begin
                state <= ST_OPEN; idx <= IDX_W'(1); sh <= s_data;
                last_q <= s_last; undr_eom <= 1'b0; ones <= '0;
              end
            end
            ST_OPEN: begin
              idx <= idx + 1'b1;
              if (idx == FLAG_LAST) begin state <= ST_DATA; idx <= '0; end
            end
            ST_DATA: begin
              if (stuff_now) ones <= '0;
              else begin
                ones <= sh[0] ? ones + 1'b1 : '0;
                sh   <= sh >> 1;
                idx  <= idx + 1'b1;
                if (idx == DATA_LAST) begin
                  idx <= '0;
                  if (!last_q && s_valid) begin
                    sh <= s_data; last_q <= s_last;
                  end else begin
                    state <= ST_CRC; undr_eom <= 1'b1;
                  end
                end
              end
            end
            ST_CRC: begin
              if (stuff_now) ones <= '0;
              else begin
                ones <= crc_bit ? ones + 1'b1 : '0;
                idx  <= idx + 1'b1;
                if (idx == CRC_LAST) begin state <= ST_CLOSE; idx <= '0; end
              end
            end
            ST_CLOSE: begin
              abort_pend <= 1'b0;
              ones <= '0;
              if (!stuff_now) begin
                idx <= idx + 1'b1;
                if (idx == FLAG_LAST) begin state <= ST_IDLE; idx <= '0; end
              end
            end
            ST_ABORT: begin
              idx <= idx + 1'b1;
              if (idx == ABORT_LAST) begin state <= ST_IDLE; idx <= '0; end
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
      if (abort_req) abort_pend <= 1'b1;
    end
  end

  hdlc_tx_crc #(.CRC_W(CRC_W), .POLY(CRC_POLY), .INIT('1)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .preset  (bit_en && state == ST_IDLE && s_valid),
    .upd_en  (bit_en && state == ST_DATA && !stuff_now && !do_abort),
    .upd_bit (sh[0]),
    .shift_en(bit_en && state == ST_CRC && !stuff_now && !do_abort),
    .out_bit (crc_bit)
  );

  hdlc_tx_line u_line (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_en (bit_en),
    .nrzi_en(nrzi_en),
    .idle   (line_idle),
    .raw_bit(raw_bit),
    .txd    (txd)
  );

  hdlc_tx_rts u_rts (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_en   (bit_en),
    .line_idle(state == ST_IDLE),
    .rts_req  (rts_req),
    .rts_out  (rts_out)
  );

  p_byte_take_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && state == ST_DATA) |=> (state == ST_DATA && idx == '0));

  p_undr_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(undr_eom) |-> (state == ST_CRC));

  p_abort_enter_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && do_abort) |=> (state == ST_ABORT));

  p_stuff_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA || state == ST_CRC) |-> (ones <= RUN_MAX));
endmodule

// File: tb/hdlc_tx_framer_bench.sv
`timescale 1ns/1ps
module hdlc_tx_framer_bench;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, nrzi_en = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0, abort_req = 1'b0, rts_req = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, txd, rts_out, undr_eom;

  always #2.5 clk = ~clk;

  hdlc_tx_framer u_hdlc_tx_framer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .nrzi_en(nrzi_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_last(s_last),
    .abort_req(abort_req), .rts_req(rts_req),
    .txd(txd), .rts_out(rts_out), .undr_eom(undr_eom)
  );

  // {nrzi, use_last, byte count, bytes (first byte in low bits)}
  localparam logic [36:0] VEC [0:5] = '{
    {1'b0, 1'b1, 3'd1, 32'h0000_0000},
    {1'b0, 1'b1, 3'd2, 32'h0000_FFFF},
    {1'b1, 1'b1, 3'd3, 32'h00A5_3C7E},
    {1'b0, 1'b0, 3'd2, 32'h0000_3412},
    {1'b1, 1'b1, 3'd4, 32'h55FF_1FF8},
    {1'b0, 1'b0, 3'd1, 32'h0000_003E}
  };

  int errors = 0, checks = 0, ones_m = 0, exp_n = 0, fnb = 0, ptr = 0;
  int stable_bad = 0, ready_bad = 0;
  bit done = 1'b0;
  logic exp_b [0:511];
  logic cap_raw [0:511], cap_dec [0:511], cap_rts [0:511];
  logic [7:0] fb [0:3];
  logic f_last = 1'b0, feed_en = 1'b0, prev_lvl = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic push(input logic b);
    exp_b[exp_n] = b; exp_n++;
  endtask

  task automatic push_st(input logic b);
    push(b);
    if (b) ones_m++; else ones_m = 0;
    if (ones_m == 5) begin push(1'b0); ones_m = 0; end
  endtask

  task automatic build();
    logic [15:0] c;
    c = 16'hFFFF; exp_n = 0; ones_m = 0;
    for (int i = 0; i < 8; i++) push(8'h7E >> i);
    for (int k = 0; k < fnb; k++)
      for (int i = 0; i < 8; i++) begin
        logic b;
        b = fb[k][i];
        push_st(b);
        c = (c >> 1) ^ ((c[0] ^ b) ? 16'h8408 : 16'h0000);
      end
    c = ~c;
    for (int i = 0; i < 16; i++) push_st(c[i]);
    for (int i = 0; i < 8; i++) push(8'h7E >> i);
  endtask

  task automatic tick(input int idx);
    logic acc;
    @(negedge clk);
    bit_en  = 1'b1;
    s_valid = feed_en && (ptr < fnb);
    s_data  = (ptr < fnb) ? fb[ptr] : 8'h00;
    s_last  = s_valid && f_last && (ptr == fnb - 1);
    #1;
    acc = s_valid && s_ready;
    @(negedge clk);
    bit_en = 1'b0;
    if (acc) ptr++;
    s_valid = feed_en && (ptr < fnb);
    s_data  = (ptr < fnb) ? fb[ptr] : 8'h00;
    s_last  = s_valid && f_last && (ptr == fnb - 1);
    cap_raw[idx] = txd;
    cap_dec[idx] = nrzi_en ? (txd == prev_lvl) : txd;
    prev_lvl     = txd;
    cap_rts[idx] = rts_out;
    @(negedge clk);
    if (s_ready) ready_bad++;
    @(negedge clk);
    if (txd !== cap_raw[idx]) stable_bad++;
  endtask

  task automatic load(input logic [36:0] v);
    nrzi_en = v[36]; f_last = v[35]; fnb = int'(v[34:32]);
    for (int k = 0; k < 4; k++) fb[k] = v[8*k +: 8];
    ptr = 0; prev_lvl = 1'b1;
  endtask

  task automatic run_frame(input logic [36:0] v, input int rts_drop, input string tag);
    int bad, hi_bad;
    load(v); build(); feed_en = 1'b1;
    tick(0);
    chk(undr_eom == 1'b0, {tag, " R6 status cleared at frame start"}, undr_eom, 0);
    for (int i = 1; i < exp_n + 4; i++) begin
      if (i == rts_drop) rts_req = 1'b0;
      tick(i);
    end
    bad = 0;
    for (int i = 0; i < exp_n; i++) if (cap_dec[i] !== exp_b[i]) bad++;
    // R2 opening flag, R3 stuffing, R4 CRC, R5 byte flow, R9 coding
    chk(bad == 0, {tag, " R2 R3 R4 R5 R9 frame bit errors"}, bad, 0);
    hi_bad = 0;
    for (int i = exp_n; i < exp_n + 4; i++) if (cap_raw[i] !== 1'b1) hi_bad++;
    chk(hi_bad == 0, {tag, " R9 line high after closing flag"}, hi_bad, 0);
    chk(undr_eom == 1'b1, {tag, " R6 status set after frame"}, undr_eom, 1);
    feed_en = 1'b0;
  endtask

  initial begin
    #600000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog R1: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(txd == 1'b1,      "R1 reset txd",      txd, 1);
    chk(rts_out == 1'b0,  "R1 reset rts_out",  rts_out, 0);
    chk(undr_eom == 1'b0, "R1 reset undr_eom", undr_eom, 0);
    chk(s_ready == 1'b0,  "R1 reset s_ready",  s_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < 6; v++) run_frame(VEC[v], -1, $sformatf("vec%0d", v));

    // R7: abort while idle is ignored
    @(negedge clk); abort_req = 1'b1;
    @(negedge clk); abort_req = 1'b0;
    run_frame(VEC[0], -1, "R7 idle-abort");

    // R8: request dropped mid-frame, held through closing flag
    rts_req = 1'b1;
    run_frame(VEC[1], 6, "R8 rts");
    chk(cap_rts[exp_n-1] == 1'b1, "R8 rts held on last flag bit", cap_rts[exp_n-1], 1);
    chk(cap_rts[exp_n]   == 1'b0, "R8 rts released after flag",  cap_rts[exp_n], 0);

    // R7: abort mid-data gives a run of ones and no closing flag
    begin
      int not_one;
      load({1'b0, 1'b1, 3'd4, 32'h5555_5555});
      feed_en = 1'b1;
      for (int i = 0; i < 14; i++) tick(i);
      @(negedge clk); abort_req = 1'b1;
      @(negedge clk); abort_req = 1'b0;
      feed_en = 1'b0;
      for (int i = 14; i < 26; i++) tick(i);
      not_one = 0;
      for (int i = 14; i < 26; i++) if (cap_raw[i] !== 1'b1) not_one++;
      chk(not_one == 0, "R7 abort ones then idle", not_one, 0);
      chk(undr_eom == 1'b0, "R7 abort skips CRC status", undr_eom, 0);
    end

    chk(stable_bad == 0, "R10 txd stable between ticks", stable_bad, 0);
    chk(ready_bad == 0,  "R1 s_ready low off tick",      ready_bad, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule